// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block paces a raster display one dot per clock. It keeps a dot position within the current line and a line number within the frame, and from these it walks a small state machine through the phases of each line. The current phase and a line-match flag are presented as a 3-bit status field. Single-cycle interrupt requests are raised when vertical blank begins and on the status events. The vertical-blank request goes to the interrupt controller. The status request covers entry to pixel transfer, entry to horizontal blank, and a line-match rising edge.

A line-compare register can be written by the CPU and read back. The line counter has no write path, so the CPU can only read it. A lock output is high for the whole pixel-transfer phase. The system bus uses it to answer CPU video-memory reads with 0xFF during that phase.

The state machine has four states: `MODE_SEARCH` (code 2), `MODE_XFER` (code 3), `MODE_HBLANK` (code 0) and `MODE_VBLANK` (code 1). Its transitions are:
- SEARCH→XFER after the last search dot.
- XFER→HBLANK after the last transfer dot.
- HBLANK→SEARCH at the end of a visible line that is not the last one.
- HBLANK→VBLANK at the end of the last visible line.
- VBLANK→SEARCH at the end of the final line of the frame.

Top module: `lcd_line_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are: line 0, compare register 0, status mode bits 1:0 = 2 (object search), lock low, no interrupt request.
- R2: Every visible line lasts 456 dots. Dots 0..79 report mode 2, dots 80..251 report mode 3 and dots 252..455 report mode 0.
- R3: Lines 144..153 report mode 1 (vertical blank) for all dots. After dot 455 of line 153 the line number returns to 0 in mode 2.
- R4: `vblank_irq_o` is high for exactly one cycle, at dot 0 of line 144. It is not raised again in the rest of vertical blank.
- R5: `status_irq_o` pulses for one cycle at dot 80 and at dot 252 of each visible line. Vertical-blank lines raise no phase pulse.
- R6: `status_o[1:0]` carries the mode code (0 hblank, 1 vblank, 2 search, 3 transfer). `status_o[2]` is 1 exactly when the line number equals the compare register.
- R7: `status_irq_o` pulses for one cycle in the first cycle in which `status_o[2]` rises. This happens either by the line advancing onto the compare value or by a compare write. A held match raises no further pulse, and the match present at reset release raises none.
- R8: A write with `cmp_we` high loads `cmp_wdata` into the compare register, and the new value is visible on `cmp_o` in the next cycle. A compare write leaves the line number unchanged.
- R9: `vram_lock_o` is high exactly in the cycles that report mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Compare register write data |
| line_o | output | 8 | Current line number (read-only) |
| cmp_o | output | 8 | Compare register read-back |
| status_o | output | 3 | Bit 2 line-match flag, bits 1:0 mode code |
| vblank_irq_o | output | 1 | One-cycle request at vertical-blank entry |
| status_irq_o | output | 1 | One-cycle request on phase entry or match rise |
| vram_lock_o | output | 1 | High during pixel transfer |

## Verification
The bench probes the dot at each side of every phase boundary:
- Dot 79/80 and dot 251/252 catch an off-by-one, which would show the wrong mode code or a misplaced pulse.
- Line 143/144 catches a wrong vertical-blank boundary.
- The 153→0 wrap catches a counter that runs past the frame.

Dot 1 of line 144 and dot 0 of line 145 would expose a design that drives the vertical-blank request as a level or re-raises it every line. Dot 80 of a blank line would expose phase pulses leaking into vertical blank.

For the match logic, the bench holds a match for a whole line and writes the compare register mid-line. A level-style or missing edge detector would then show repeated or absent status pulses. A spurious pulse at reset release would also show up.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

endpackage

// File: rtl/lcd_dot_line_counter.sv
module lcd_dot_line_counter #(
    parameter int DOTS_PER_LINE = 456,
    parameter int TOTAL_LINES   = 154,
    parameter int DOT_W         = 9,
    parameter int LINE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [DOT_W-1:0]  dot_o,
    output logic [LINE_W-1:0] line_o,
    output logic              line_last_dot_o,
    output logic              frame_last_dot_o
);

    localparam logic [DOT_W-1:0]  LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot_q  <= '0;
            line_q <= '0;
        end else if (dot_q == LAST_DOT) begin
            dot_q  <= '0;
            line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
        end else begin
            dot_q <= dot_q + 1'b1;
        end
    end

    assign dot_o            = dot_q;
    assign line_o           = line_q;
    assign line_last_dot_o  = (dot_q == LAST_DOT);
    assign frame_last_dot_o = (dot_q == LAST_DOT) && (line_q == LAST_LINE);

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_last_dot_o |=> (line_q == '0) && (dot_q == '0)); // R3

    AST_DOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_q <= LAST_DOT) && (line_q <= LAST_LINE)); // R2

endmodule

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_seq_pkg::*;
#(
    parameter int SEARCH_DOTS = 80,
    parameter int XFER_DOTS   = 172,
    parameter int VIS_LINES   = 144,
    parameter int DOT_W       = 9,
    parameter int LINE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic              line_last_dot_i,
    input  logic              frame_last_dot_i,
    output lcd_mode_e         mode_o,
    output logic              vram_lock_o,
    output logic              vblank_irq_o,
    output logic              phase_irq_o
);

    localparam logic [DOT_W-1:0]  SEARCH_END = DOT_W'(SEARCH_DOTS - 1);
    localparam logic [DOT_W-1:0]  XFER_END   = DOT_W'(SEARCH_DOTS + XFER_DOTS - 1);
    localparam logic [LINE_W-1:0] LAST_VIS   = LINE_W'(VIS_LINES - 1);

    lcd_mode_e state_q, state_d, prev_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SEARCH: if (dot_i == SEARCH_END) state_d = MODE_XFER;
            MODE_XFER:   if (dot_i == XFER_END)   state_d = MODE_HBLANK;
            MODE_HBLANK: if (line_last_dot_i)
                             state_d = (line_i == LAST_VIS) ? MODE_VBLANK : MODE_SEARCH;
            MODE_VBLANK: if (frame_last_dot_i)    state_d = MODE_SEARCH;
            default:     state_d = MODE_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_SEARCH;
            prev_q  <= MODE_SEARCH;
        end else begin
            state_q <= state_d;
            prev_q  <= state_q;
        end
    end

    always_comb begin
        mode_o       = state_q;
        vram_lock_o  = 1'b0;
        vblank_irq_o = 1'b0;
        phase_irq_o  = 1'b0;
        unique case (state_q)
            MODE_XFER: begin
                vram_lock_o = 1'b1;
                phase_irq_o = (prev_q != MODE_XFER);
            end
            MODE_HBLANK: phase_irq_o  = (prev_q != MODE_HBLANK);
            MODE_VBLANK: vblank_irq_o = (prev_q != MODE_VBLANK);
            MODE_SEARCH: ;
            default: ;
        endcase
    end

    AST_VBLANK_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq_o |-> (line_i == LINE_W'(VIS_LINES)) && (dot_i == '0)); // R4

    AST_XFER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_XFER) |-> (dot_i > SEARCH_END) && (dot_i <= XFER_END)); // R2

    AST_NO_PHASE_IN_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i >= LINE_W'(VIS_LINES)) |-> !phase_irq_o && (state_q == MODE_VBLANK)); // R3

endmodule

// File: rtl/lcd_line_compare.sv
module lcd_line_compare #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic [LINE_W-1:0] line_i,
    output logic [LINE_W-1:0] cmp_o,
    output logic              match_o,
    output logic              match_irq_o
);

    logic [LINE_W-1:0] cmp_q;
    logic              match_prev_q;
    logic              match_now;

    assign match_now = (line_i == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q        <= '0;
            match_prev_q <= 1'b1;
        end else begin
            if (wr_en_i) cmp_q <= wr_data_i;
            match_prev_q <= match_now;
        end
    end

    assign cmp_o       = cmp_q;
    assign match_o     = match_now;
    assign match_irq_o = match_now && !match_prev_q;

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq_o |=> !match_irq_o); // R7

    AST_CMP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (cmp_o == $past(wr_data_i))); // R8

endmodule

// File: rtl/lcd_line_sequencer.sv
module lcd_line_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int SEARCH_DOTS   = 80,
    parameter int XFER_DOTS     = 172,
    parameter int VIS_LINES     = 144,
    parameter int TOTAL_LINES   = 154,
    parameter int LINE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_we,
    input  logic [LINE_W-1:0] cmp_wdata,
    output logic [LINE_W-1:0] line_o,
    output logic [LINE_W-1:0] cmp_o,
    output logic [2:0]        status_o,
    output logic              vblank_irq_o,
    output logic              status_irq_o,
    output logic              vram_lock_o
);

    localparam int DOT_W = $clog2(DOTS_PER_LINE);

    logic [DOT_W-1:0]  dot;
    logic [LINE_W-1:0] line;
    logic              line_last_dot, frame_last_dot;
    lcd_mode_e         mode;
    logic              phase_irq, match, match_irq;

    lcd_dot_line_counter #(
        .DOTS_PER_LINE(DOTS_PER_LINE), .TOTAL_LINES(TOTAL_LINES),
        .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) counter_i (
        .clk(clk), .rst_n(rst_n), .dot_o(dot), .line_o(line),
        .line_last_dot_o(line_last_dot), .frame_last_dot_o(frame_last_dot)
    );

    lcd_mode_fsm #(
        .SEARCH_DOTS(SEARCH_DOTS), .XFER_DOTS(XFER_DOTS), .VIS_LINES(VIS_LINES),
        .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .dot_i(dot), .line_i(line),
        .line_last_dot_i(line_last_dot), .frame_last_dot_i(frame_last_dot),
        .mode_o(mode), .vram_lock_o(vram_lock_o),
        .vblank_irq_o(vblank_irq_o), .phase_irq_o(phase_irq)
    );

    lcd_line_compare #(.LINE_W(LINE_W)) compare_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(cmp_we), .wr_data_i(cmp_wdata),
        .line_i(line), .cmp_o(cmp_o), .match_o(match), .match_irq_o(match_irq)
    );

    assign line_o       = line;
    assign status_o     = {match, mode};
    assign status_irq_o = phase_irq | match_irq;

    AST_LOCK_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        vram_lock_o |-> (status_o[1:0] == 2'd3)); // R9

    AST_VBLANK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_irq_o |=> !vblank_irq_o); // R4

    AST_WRITE_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_we && !line_last_dot) |=> (line_o == $past(line_o))); // R8

endmodule

// File: tb/lcd_line_sequencer_tb_top.sv
`timescale 1ns/1ps
module lcd_line_sequencer_tb_top;

    localparam int DPL = 456;
    localparam int FRAME = 154 * DPL;
    localparam int N = 18;
    // absolute line (154 = wrapped line 0), dot, status, {vblank, status irq, lock}
    localparam int VL[N] = '{0, 0, 0, 0, 0, 0, 0, 1, 1, 143, 143, 144, 144, 144, 145, 153, 154, 154};
    localparam int VD[N] = '{0, 79, 80, 81, 251, 252, 455, 0, 80, 252, 455, 0, 1, 80, 0, 455, 0, 1};
    localparam int VS[N] = '{6, 6, 7, 7, 7, 4, 4, 2, 3, 0, 0, 1, 1, 1, 1, 1, 6, 6};
    localparam int VF[N] = '{0, 0, 3, 1, 1, 2, 0, 0, 3, 2, 0, 4, 0, 0, 0, 0, 2, 0};
    localparam string VR[N] = '{"R1", "R2", "R5", "R9", "R2", "R5", "R2", "R6", "R5",
                                "R5", "R2", "R4", "R4", "R3", "R4", "R3", "R7", "R3"};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = '0;
    logic [7:0] line_o, cmp_o;
    logic [2:0] status_o;
    logic       vblank_irq_o, status_irq_o, vram_lock_o;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    lcd_line_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .line_o(line_o), .cmp_o(cmp_o), .status_o(status_o),
        .vblank_irq_o(vblank_irq_o), .status_irq_o(status_irq_o), .vram_lock_o(vram_lock_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic chk_all(input string req, input int ln, input int st, input int fl);
        chk(req, "line", int'(line_o), ln);
        chk(req, "status", int'(status_o), st);
        chk(req, "vblank_irq", int'(vblank_irq_o), (fl >> 2) & 1);
        chk(req, "status_irq", int'(status_irq_o), (fl >> 1) & 1);
        chk(req, "vram_lock", int'(vram_lock_o), fl & 1);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        chk_all("R1", 0, 6, 0);
        chk("R1", "cmp", int'(cmp_o), 0);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            wait_to(VL[i] * DPL + VD[i]);
            chk_all(VR[i], VL[i] % 154, VS[i], VF[i]);
        end

        // R8: compare write, read-back, line unaffected; R6 match falls
        base = FRAME + 10;
        wait_to(base);
        cmp_we = 1'b1; cmp_wdata = 8'd5;
        @(negedge clk);
        cmp_we = 1'b0;
        chk("R8", "cmp readback", int'(cmp_o), 5);
        chk("R8", "line unchanged", int'(line_o), 0);
        chk("R6", "match cleared", int'(status_o[2]), 0);
        chk("R7", "no pulse on fall", int'(status_irq_o), 0);

        // R7: match rises when line reaches compare, single pulse while held
        wait_to(FRAME + 5 * DPL);
        chk("R7", "match rise pulse", int'(status_irq_o), 1);
        chk("R6", "match flag", int'(status_o), 6);
        @(negedge clk);
        chk("R7", "held match no pulse", int'(status_irq_o), 0);
        chk("R6", "match held", int'(status_o[2]), 1);
        wait_to(FRAME + 5 * DPL + 100);
        chk("R7", "held match mid-line", int'(status_irq_o), 0);
        chk("R9", "lock in transfer", int'(vram_lock_o), 1);
        wait_to(FRAME + 6 * DPL);
        chk("R6", "match off next line", int'(status_o[2]), 0);

        // R7: compare written to current line mid-line
        base = FRAME + 7 * DPL + 300;
        wait_to(base);
        cmp_we = 1'b1; cmp_wdata = 8'd7;
        @(negedge clk);
        cmp_we = 1'b0;
        chk("R7", "write-match pulse", int'(status_irq_o), 1);
        chk("R6", "write-match status", int'(status_o), 4);
        chk("R8", "line after write", int'(line_o), 7);
        @(negedge clk);
        chk("R7", "write-match single", int'(status_irq_o), 0);

        // R1: reset mid-frame
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R1", 0, 6, 0);
        chk("R1", "cmp after reset", int'(cmp_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1", 0, 6, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule